// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is the management-side slave of an Ethernet PHY. It runs on the management clock, watches the bidirectional management data line and decodes 16-bit read and write frames in the clause-22 style. A frame may begin with a run of 32 ones, or that run may be left out entirely. A frame is answered only when its 5-bit PHY address field equals the address captured from the strap inputs during hardware reset.

The block holds a small register file. It covers the basic control word, the read-only status word, a summary word for quick polling, a PCS configuration word, a loopback/bypass word and a PHY control word. The PHY control word exposes the captured address in its low bits. The control word drives the isolate, loopback and soft-reset outputs that steer the datapath. The remote-fault status bit is latched: once it is set, it stays set until management reads the status word. If the captured address is all zeros, the block comes out of reset isolated.

Top module: `mdio_regslave`

## Requirements
- R1: A frame is an optional run of 32 ones, then start bits 0,1, then op code (1,0 = read; 0,1 = write), then a 5-bit PHY address and a 5-bit register address, then 2 turnaround bits and 16 data bits. All fields are MSB first and sampled on the rising clock edge. Frames with and without the leading ones are both accepted.
- R2: Only frames whose PHY address field equals the address captured at hardware reset are served. For any other address the block never enables its MDIO driver, and a write changes no register.
- R3: On a served read, the driver is off for the first turnaround bit. It drives 0 for the second. It then drives the 16 data bits MSB first, each changing after a rising edge, and turns off after the last bit.
- R4: Control bit 10 (isolate) resets to 1 when the captured address is 00000 and to 0 otherwise. The isolate output always equals this bit.
- R5: Control word 00h keeps bits 14:8 as written: 14 loopback, 13 speed-100, 12 auto-negotiation enable, 11 power down, 10 isolate, 9 restart, 8 full duplex. Bits 7:0 read 0. The reset value is 0x3000, plus 0x0400 when isolated. The loopback output equals bit 14.
- R6: Writing 00h with bit 15 set returns every writable register to its reset value. Bit 15 then reads 1 and soft_rst stays high for RST_CYCLES clock cycles, after which both read 0.
- R7: Status word 01h is read-only. It reads 0x7849, with bit 6 set to show that frames without leading ones are accepted, plus 0x0010 when bit 4 (remote fault) is set and 0x0004 when link_ok is high.
- R8: A one-cycle pulse on rfault_in sets status bit 4, and the bit stays set until the next read of 01h, after which it reads 0. Reading 10h does not clear it.
- R9: Summary word 10h reads bit 3 = loopback (control bit 14), bit 2 = full duplex (control bit 8), bit 1 = 1 when control bit 13 is 0, and bit 0 = link_ok. All other bits read 0.
- R10: Registers 16h and 17h are fully read/write with reset value 0. In 19h, bits 15:5 are read/write with reset value 0, and bits 4:0 always read the captured PHY address.
- R11: Register addresses other than 00h, 01h, 10h, 16h, 17h and 19h read 0x0000, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all logic on its rising edge |
| rst | input | 1 | Hardware reset, active high; captures strap_addr |
| strap_addr | input | 5 | PHY address straps, sampled during reset |
| mdio_in | input | 1 | Resolved level of the management data line |
| mdio_out | output | 1 | Value driven on the data line when enabled |
| mdio_oe | output | 1 | Data line driver enable |
| link_ok | input | 1 | Link status from the datapath |
| rfault_in | input | 1 | Remote fault event from the datapath |
| isolate | output | 1 | Datapath must ignore transmit inputs and float its MII outputs |
| loopback | output | 1 | Loopback request to the datapath |
| soft_rst | output | 1 | High while a software reset is in progress |

## Verification
Call the rising edge that samples the last register-address bit edge k. The read value is captured at edge k. The driver stays off after edge k, drives 0 after edge k+1, and drives data bit 15-n after edge k+2+n. It turns off after edge k+18, which is also the edge that commits a write. The bench drives every bit and samples every result at the falling edge that follows the relevant rising edge, so each turnaround, data and release value is checked in its own bit period. Output ports are checked only after the frame that changed them has ended. The hardware reset behaviour is swept over all 32 strap addresses, alternating frames with and without the leading ones, and every read is matched against a word built from the requirement's bit positions.

// File: rtl/mdio_regslave.sv
module mdio_regslave #(
  parameter int RST_CYCLES = 64
) (
  input  logic       mdc,
  input  logic       rst,
  input  logic [4:0] strap_addr,
  input  logic       mdio_in,
  output logic       mdio_out,
  output logic       mdio_oe,
  input  logic       link_ok,
  input  logic       rfault_in,
  output logic       isolate,
  output logic       loopback,
  output logic       soft_rst
);

  localparam int CW = $clog2(RST_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_HDR, S_TA, S_DATA} st_t;

  st_t         st;
  logic [4:0]  cnt, addr_q, ra_q;
  logic [11:0] hdr;
  logic [15:0] sr, ctrl_q, pcs_q, lb_q, rdata;
  logic [10:0] pctl_q;
  logic        rd_q, wr_q, rf_q;
  logic [CW-1:0] rcnt;

  wire [11:0] hdr_w  = {hdr[10:0], mdio_in};
  wire        hdr_end = (st == S_HDR) && (cnt == 5'd11);
  wire        hit    = (hdr_w[9:5] == addr_q);
  wire        go_rd  = hdr_end && hit && (hdr_w[11:10] == 2'b10);
  wire        go_wr  = hdr_end && hit && (hdr_w[11:10] == 2'b01);
  wire [15:0] wdata  = {sr[14:0], mdio_in};
  wire        commit = (st == S_DATA) && (cnt == 5'd15) && wr_q;
  wire        busy   = (rcnt != '0);

  wire [15:0] status_w  = {1'b0, 4'b1111, 4'b0000, 1'b1, 1'b0, rf_q, 1'b1, link_ok, 1'b0, 1'b1};
  wire [15:0] summary_w = {12'b0, ctrl_q[14], ctrl_q[8], ~ctrl_q[13], link_ok};

  always_comb begin
    case (hdr_w[4:0])
      5'h00:   rdata = {busy, ctrl_q[14:0]};
      5'h01:   rdata = status_w;
      5'h10:   rdata = summary_w;
      5'h16:   rdata = pcs_q;
      5'h17:   rdata = lb_q;
      5'h19:   rdata = {pctl_q, addr_q};
      default: rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge mdc or posedge rst) begin
    if (rst) begin
      st <= S_IDLE;
      cnt <= '0;
      hdr <= '0;
      sr <= '0;
      ra_q <= '0;
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      mdio_out <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      case (st)
        S_IDLE:  if (!mdio_in) st <= S_START;
        S_START: if (mdio_in) begin st <= S_HDR; cnt <= '0; end
        S_HDR: begin
          hdr <= hdr_w;
          cnt <= cnt + 5'd1;
          if (cnt == 5'd11) begin
            st <= S_TA;
            cnt <= '0;
            rd_q <= go_rd;
            wr_q <= go_wr;
            ra_q <= hdr_w[4:0];
            sr <= rdata;
          end
        end
        S_TA: begin
          cnt <= cnt + 5'd1;
          if (cnt == 5'd0) begin
            mdio_oe <= rd_q;
            mdio_out <= 1'b0;
          end else begin
            st <= S_DATA;
            cnt <= '0;
            mdio_out <= sr[15];
            sr <= {sr[14:0], 1'b0};
          end
        end
        S_DATA: begin
          cnt <= cnt + 5'd1;
          mdio_out <= sr[15];
          sr <= {sr[14:0], mdio_in};
          if (cnt == 5'd15) begin
            st <= S_IDLE;
            mdio_oe <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge mdc or posedge rst) begin
    if (rst) begin
      addr_q <= strap_addr;
      ctrl_q <= {2'b00, 2'b11, 1'b0, (strap_addr == 5'd0), 10'b0};
      pcs_q <= '0;
      lb_q <= '0;
      pctl_q <= '0;
      rf_q <= 1'b0;
      rcnt <= '0;
    end else begin
      if (busy) rcnt <= rcnt - 1'b1;
      if (rfault_in) rf_q <= 1'b1;
      else if (go_rd && hdr_w[4:0] == 5'h01) rf_q <= 1'b0;
      if (commit) begin
        case (ra_q)
          5'h00: begin
            if (wdata[15]) begin
              ctrl_q <= {2'b00, 2'b11, 1'b0, (addr_q == 5'd0), 10'b0};
              pcs_q <= '0;
              lb_q <= '0;
              pctl_q <= '0;
              rf_q <= rfault_in;
              rcnt <= CW'(RST_CYCLES);
            end else begin
              ctrl_q <= wdata & 16'h7F00;
            end
          end
          5'h16:   pcs_q <= wdata;
          5'h17:   lb_q <= wdata;
          5'h19:   pctl_q <= wdata[15:5];
          default: ;
        endcase
      end
    end
  end

  assign isolate  = ctrl_q[10];
  assign loopback = ctrl_q[14];
  assign soft_rst = busy;

  // R3
  ta_zero_chk: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_out);

  // R2
  oe_window_chk: assert property (@(posedge mdc) disable iff (rst)
    mdio_oe |-> ((st == S_TA || st == S_DATA) && rd_q));

  // R4
  iso_default_chk: assert property (@(posedge mdc) disable iff (rst)
    $past(rst) |-> (isolate == (addr_q == 5'd0)));

  // R8
  rf_hold_chk: assert property (@(posedge mdc) disable iff (rst)
    $past(rfault_in) |-> rf_q);

  // R6
  sreset_chk: assert property (@(posedge mdc) disable iff (rst)
    (commit && ra_q == 5'h00 && wdata[15]) |=> (soft_rst && !loopback && pcs_q == 16'h0000));

endmodule

// File: tb/mdio_regslave_bench.sv
module mdio_regslave_bench;
  localparam int CLK_PERIOD = 10;

  logic       mdc = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] strap = 5'd0;
  logic       m_oe = 1'b0, m_drv = 1'b1;
  logic       link_ok = 1'b0, rfault_in = 1'b0;
  logic       d_out, d_oe, isolate, loopback, soft_rst;
  wire        line = d_oe ? d_out : (m_oe ? m_drv : 1'b1);
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) mdc = ~mdc;

  mdio_regslave u_mdio_regslave (
    .mdc(mdc), .rst(rst), .strap_addr(strap), .mdio_in(line),
    .mdio_out(d_out), .mdio_oe(d_oe), .link_ok(link_ok), .rfault_in(rfault_in),
    .isolate(isolate), .loopback(loopback), .soft_rst(soft_rst));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge mdc);
    m_oe = 1'b1;
    m_drv = b;
  endtask

  task automatic send_hdr(input bit pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    if (pre) repeat (32) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(pa[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  task automatic mdio_rd(input bit pre, input logic [4:0] pa, input logic [4:0] ra,
                         output logic [15:0] d, output bit ta_ok, output bit oe_seen);
    send_hdr(pre, 2'b10, pa, ra);
    @(negedge mdc);
    m_oe = 1'b0;
    ta_ok = !d_oe;
    oe_seen = d_oe;
    @(negedge mdc);
    ta_ok &= d_oe && !d_out;
    oe_seen |= d_oe;
    d = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge mdc);
      d = {d[14:0], d_out};
      ta_ok &= d_oe;
      oe_seen |= d_oe;
    end
    @(negedge mdc);
    ta_ok &= !d_oe;
    oe_seen |= d_oe;
  endtask

  task automatic mdio_wr(input bit pre, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] v);
    send_hdr(pre, 2'b01, pa, ra);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(v[i]);
    @(negedge mdc);
    m_oe = 1'b0;
  endtask

  task automatic do_reset(input logic [4:0] a);
    strap = a;
    rst = 1'b1;
    repeat (3) @(negedge mdc);
    rst = 1'b0;
    @(negedge mdc);
  endtask

  initial begin
    repeat (150000) @(posedge mdc);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bit ok, seen;
    logic [4:0] A;

    // Sweep all strap addresses: isolate default, address match, turnaround
    for (int a = 0; a < 32; a++) begin
      do_reset(5'(a));
      chk("R4 isolate out", {15'b0, isolate}, {15'b0, (a == 0)});
      mdio_rd(a[0], 5'(a), 5'h00, d, ok, seen);
      chk("R5 ctrl default", d, 16'h3000 | ((a == 0) ? 16'h0400 : 16'h0));
      chk("R3 turnaround", {15'b0, ok}, 16'h1);
      mdio_rd(!a[0], 5'(a), 5'h19, d, ok, seen);
      chk("R10 addr field", d, 16'(a));
      mdio_rd(1'b0, 5'(a) ^ 5'h11, 5'h00, d, ok, seen);
      chk("R2 no drive", {15'b0, seen}, 16'h0);
    end

    A = 5'h03;
    do_reset(A);
    // R1 preamble with write, no preamble on read
    mdio_wr(1'b1, A, 5'h16, 16'hA5C3);
    mdio_rd(1'b0, A, 5'h16, d, ok, seen);
    chk("R1 r10_ pcs rw", d, 16'hA5C3);
    mdio_wr(1'b0, A, 5'h17, 16'h5A3C);
    mdio_rd(1'b1, A, 5'h17, d, ok, seen);
    chk("R1 r10_ lb rw", d, 16'h5A3C);
    mdio_wr(1'b0, A, 5'h19, 16'hFFFF);
    mdio_rd(1'b0, A, 5'h19, d, ok, seen);
    chk("R10 phyctl ro addr", d, 16'hFFE3);
    // R2 write to another address ignored
    mdio_wr(1'b0, A ^ 5'h01, 5'h16, 16'h0F0F);
    mdio_rd(1'b0, A, 5'h16, d, ok, seen);
    chk("R2 foreign write", d, 16'hA5C3);
    // R11 unimplemented
    mdio_wr(1'b0, A, 5'h05, 16'h1234);
    mdio_rd(1'b0, A, 5'h05, d, ok, seen);
    chk("R11 unimpl read", d, 16'h0000);
    mdio_rd(1'b0, A, 5'h1F, d, ok, seen);
    chk("R11 unimpl 1f", d, 16'h0000);
    mdio_rd(1'b0, A, 5'h16, d, ok, seen);
    chk("R11 no side effect", d, 16'hA5C3);
    // R5 control bits and outputs
    mdio_wr(1'b0, A, 5'h00, 16'h7FFF);
    mdio_rd(1'b0, A, 5'h00, d, ok, seen);
    chk("R5 ctrl mask", d, 16'h7F00);
    chk("R5 loopback out", {15'b0, loopback}, 16'h1);
    chk("R4 isolate follows", {15'b0, isolate}, 16'h1);
    link_ok = 1'b1;
    mdio_rd(1'b0, A, 5'h10, d, ok, seen);
    chk("R9 summary a", d, 16'h000D);
    mdio_wr(1'b0, A, 5'h00, 16'h0100);
    link_ok = 1'b0;
    mdio_rd(1'b0, A, 5'h10, d, ok, seen);
    chk("R9 summary b", d, 16'h0006);
    chk("R5 loopback off", {14'b0, loopback, isolate}, 16'h0);
    // R7 status
    mdio_wr(1'b0, A, 5'h01, 16'hFFFF);
    mdio_rd(1'b0, A, 5'h01, d, ok, seen);
    chk("R7 status ro", d, 16'h7849);
    link_ok = 1'b1;
    mdio_rd(1'b1, A, 5'h01, d, ok, seen);
    chk("R7 status link", d, 16'h784D);
    link_ok = 1'b0;
    // R8 remote fault latch
    @(negedge mdc); rfault_in = 1'b1;
    @(negedge mdc); rfault_in = 1'b0;
    mdio_rd(1'b0, A, 5'h10, d, ok, seen);
    mdio_rd(1'b0, A, 5'h01, d, ok, seen);
    chk("R8 rf latched", d, 16'h7859);
    mdio_rd(1'b0, A, 5'h01, d, ok, seen);
    chk("R8 rf cleared", d, 16'h7849);
    // R6 software reset
    mdio_wr(1'b0, A, 5'h00, 16'h4000);
    mdio_wr(1'b0, A, 5'h00, 16'h8000);
    chk("R6 soft_rst high", {14'b0, soft_rst, loopback}, 16'h2);
    mdio_rd(1'b0, A, 5'h00, d, ok, seen);
    chk("R6 busy bit", d, 16'hB000);
    mdio_rd(1'b0, A, 5'h16, d, ok, seen);
    chk("R6 pcs default", d, 16'h0000);
    repeat (80) @(negedge mdc);
    chk("R6 soft_rst low", {15'b0, soft_rst}, 16'h0);
    mdio_rd(1'b0, A, 5'h00, d, ok, seen);
    chk("R6 self clear", d, 16'h3000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule